// File: doc/BRIEF.md
# Read-Set Semaphore Bank

This block is a bus slave that holds a small bank of 32-bit lock registers shared by every processor on a common bus. Reading a lock through its claim window returns the value the lock held before the access and, in the same access, loads the lock with the taken value 1. A single read therefore behaves as an atomic test-and-set, and no locked bus sequence is needed. Software that reads back 0 owns the lock. Software that reads back 1 retries later.

A second window maps the same locks again. Reads through this window return the lock value and leave it unchanged, so software can poll a lock without claiming it. A write through either window stores the written word. Writing 0 frees the lock.

The port is a plain request/ready slave. Each clock cycle with the request high is one access. The response, with ready high and the read word, appears on the following cycle. The offset is a word index. Offsets `0..NUM_SEM-1` form the claim window. Offsets `NUM_SEM..2*NUM_SEM-1` form the test window. Any higher offset is unmapped.

Top module: `sema_bank`

## Requirements
- R1: After reset every lock holds 0, `ready_o` is low and `rdata_o` is 0.
- R2: `ready_o` is high in exactly those cycles that follow a cycle with `req_i` high. A request may be presented every cycle.
- R3: A read at offset i, with i below NUM_SEM, returns on `rdata_o` the value lock i held before that access.
- R4: After such a claim read, lock i holds 1. This is visible through the test window at offset NUM_SEM+i.
- R5: A read at offset NUM_SEM+i returns the value of lock i and leaves that value unchanged.
- R6: A write at offset i or NUM_SEM+i stores `wdata_i` in lock i. Any 32-bit value is stored, and 0 means free.
- R7: An offset of 2*NUM_SEM or above reads as 0. Reads and writes at such an offset change no lock.
- R8: When two claim reads of the same free lock arrive on consecutive cycles, the first returns 0 and the second returns 1.
- R9: `rdata_o` is 0 in every cycle that does not answer a mapped read, which covers write responses and idle cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Access request; each high cycle is one access |
| wr_i | input | 1 | 1 for a write, 0 for a read |
| addr_i | input | ADDR_W | Word offset inside the reserved region |
| wdata_i | input | DATA_W | Write data |
| ready_o | output | 1 | Response valid, one cycle after the request |
| rdata_o | output | DATA_W | Read data for the access being answered |

## Verification
A wrong lock state cannot be seen directly. It shows up on `rdata_o` at the next read of that lock through either window, one cycle after that read is presented. The reference model therefore follows every access, and the bench compares `ready_o` and `rdata_o` on every cycle. The bench polls through the test window after claims, writes and unmapped accesses, so that a wrong state is exposed within a few cycles instead of waiting for a later claim. Back-to-back claims of one lock check that the set value becomes visible to the very next access.

// File: rtl/sema_pkg.sv
package sema_pkg;

    // Kind of access selected by the word offset
    typedef enum logic [1:0] {
        ACC_CLAIM = 2'd0,
        ACC_TEST  = 2'd1,
        ACC_NONE  = 2'd2
    } acc_kind_e;

endpackage

// File: rtl/sema_addr_dec.sv
module sema_addr_dec
    import sema_pkg::*;
#(
    parameter int NUM_SEM = 8,
    parameter int ADDR_W  = 6,
    localparam int IDX_W  = $clog2(NUM_SEM)
) (
    input  logic [ADDR_W-1:0] addr_i,
    output acc_kind_e         kind_o,
    output logic [IDX_W-1:0]  idx_o
);

    localparam logic [ADDR_W:0] CLAIM_END = (ADDR_W+1)'(NUM_SEM);
    localparam logic [ADDR_W:0] TEST_END  = (ADDR_W+1)'(2 * NUM_SEM);

    // NUM_SEM is a power of two, so both windows share the low offset bits
    always_comb begin
        idx_o = addr_i[IDX_W-1:0];
        if ({1'b0, addr_i} < CLAIM_END) begin
            kind_o = ACC_CLAIM;
        end else if ({1'b0, addr_i} < TEST_END) begin
            kind_o = ACC_TEST;
        end else begin
            kind_o = ACC_NONE;
        end
    end

endmodule

// File: rtl/sema_cell.sv
module sema_cell #(
    parameter int          DATA_W  = 32,
    parameter logic [31:0] SET_VAL = 32'd1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              claim_i,
    input  logic              store_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] val_o
);

    logic [DATA_W-1:0] val_d, val_q;

    always_comb begin
        val_d = val_q;
        if (store_i) begin
            val_d = wdata_i;
        end else if (claim_i) begin
            val_d = DATA_W'(SET_VAL);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            val_q <= '0;
        end else begin
            val_q <= val_d;
        end
    end

    assign val_o = val_q;

endmodule

// File: rtl/sema_rsp.sv
module sema_rsp #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_i,
    input  logic              rd_hit_i,
    input  logic [DATA_W-1:0] rd_val_i,
    output logic              ready_o,
    output logic [DATA_W-1:0] rdata_o
);

    typedef struct packed {
        logic              ready;
        logic [DATA_W-1:0] data;
    } rsp_t;

    rsp_t rsp_d, rsp_q;

    always_comb begin
        rsp_d.ready = acc_i;
        rsp_d.data  = rd_hit_i ? rd_val_i : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_q <= '0;
        end else begin
            rsp_q <= rsp_d;
        end
    end

    assign ready_o = rsp_q.ready;
    assign rdata_o = rsp_q.data;

endmodule

// File: rtl/sema_bank.sv
module sema_bank
    import sema_pkg::*;
#(
    parameter int          NUM_SEM = 8,
    parameter int          ADDR_W  = 6,
    parameter int          DATA_W  = 32,
    parameter logic [31:0] SET_VAL = 32'd1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_i,
    input  logic              wr_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic              ready_o,
    output logic [DATA_W-1:0] rdata_o
);

    localparam int IDX_W = $clog2(NUM_SEM);

    acc_kind_e         dec_kind;
    logic [IDX_W-1:0]  dec_idx;
    logic [DATA_W-1:0] sem_val [NUM_SEM];
    logic              mapped;
    logic              rd_hit;
    logic [DATA_W-1:0] rd_val;

    sema_addr_dec #(
        .NUM_SEM (NUM_SEM),
        .ADDR_W  (ADDR_W)
    ) dec_i (
        .addr_i (addr_i),
        .kind_o (dec_kind),
        .idx_o  (dec_idx)
    );

    assign mapped = (dec_kind != ACC_NONE);

    for (genvar g = 0; g < NUM_SEM; g++) begin : g_cell
        logic hit;
        assign hit = req_i && mapped && (dec_idx == IDX_W'(g));
        sema_cell #(
            .DATA_W  (DATA_W),
            .SET_VAL (SET_VAL)
        ) cell_i (
            .clk     (clk),
            .rst_n   (rst_n),
            .claim_i (hit && !wr_i && (dec_kind == ACC_CLAIM)),
            .store_i (hit && wr_i),
            .wdata_i (wdata_i),
            .val_o   (sem_val[g])
        );
    end

    assign rd_hit = req_i && !wr_i && mapped;
    assign rd_val = sem_val[dec_idx];

    sema_rsp #(
        .DATA_W (DATA_W)
    ) rsp_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .acc_i    (req_i),
        .rd_hit_i (rd_hit),
        .rd_val_i (rd_val),
        .ready_o  (ready_o),
        .rdata_o  (rdata_o)
    );

endmodule

// File: rtl/sema_bank_chk.sv
module sema_bank_chk #(
    parameter int          NUM_SEM = 8,
    parameter int          ADDR_W  = 6,
    parameter int          DATA_W  = 32,
    parameter logic [31:0] SET_VAL = 32'd1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_i,
    input logic              wr_i,
    input logic [ADDR_W-1:0] addr_i,
    input logic [DATA_W-1:0] wdata_i,
    input logic              ready_o,
    input logic [DATA_W-1:0] rdata_o,
    input logic [DATA_W-1:0] sem_val_i [NUM_SEM]
);

    localparam int IDX_W = $clog2(NUM_SEM);

    logic              in_claim, in_test;
    logic [IDX_W-1:0]  cur_idx;
    logic              p_claim, p_test, p_store, p_quiet;
    logic [IDX_W-1:0]  p_idx;
    logic [DATA_W-1:0] p_val, p_wdata;

    assign in_claim = int'(addr_i) < NUM_SEM;
    assign in_test  = !in_claim && (int'(addr_i) < 2 * NUM_SEM);
    assign cur_idx  = IDX_W'(int'(addr_i) % NUM_SEM);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            p_claim <= 1'b0;
            p_test  <= 1'b0;
            p_store <= 1'b0;
            p_quiet <= 1'b0;
            p_idx   <= '0;
            p_val   <= '0;
            p_wdata <= '0;
        end else begin
            p_claim <= req_i && !wr_i && in_claim;
            p_test  <= req_i && !wr_i && in_test;
            p_store <= req_i && wr_i && (in_claim || in_test);
            p_quiet <= !req_i || wr_i || !(in_claim || in_test);
            p_idx   <= cur_idx;
            p_val   <= sem_val_i[cur_idx];
            p_wdata <= wdata_i;
        end
    end

    // R2
    ready_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_i |=> ready_o);

    // R2
    ready_only_after_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_i |=> !ready_o);

    // R3
    claim_returns_old_chk: assert property (@(posedge clk) disable iff (!rst_n)
        p_claim |-> (rdata_o == p_val));

    // R4
    claim_sets_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        p_claim |-> (sem_val_i[p_idx] == DATA_W'(SET_VAL)));

    // R5
    test_keeps_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        p_test |-> (rdata_o == p_val && sem_val_i[p_idx] == p_val));

    // R6
    write_stores_chk: assert property (@(posedge clk) disable iff (!rst_n)
        p_store |-> (sem_val_i[p_idx] == p_wdata));

    // R9
    quiet_data_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        p_quiet |-> (rdata_o == '0));

endmodule

bind sema_bank sema_bank_chk #(
    .NUM_SEM (NUM_SEM),
    .ADDR_W  (ADDR_W),
    .DATA_W  (DATA_W),
    .SET_VAL (SET_VAL)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_i     (req_i),
    .wr_i      (wr_i),
    .addr_i    (addr_i),
    .wdata_i   (wdata_i),
    .ready_o   (ready_o),
    .rdata_o   (rdata_o),
    .sem_val_i (sem_val)
);

// File: tb/sema_bank_tb_top.sv
`timescale 1ns/1ps
module sema_bank_tb_top;

    localparam int N      = 8;
    localparam int ADDR_W = 6;
    localparam int DATA_W = 32;
    localparam real CLK_NS = 8.0;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_i = 1'b0;
    logic              wr_i = 1'b0;
    logic [ADDR_W-1:0] addr_i = '0;
    logic [DATA_W-1:0] wdata_i = '0;
    logic              ready_o;
    logic [DATA_W-1:0] rdata_o;

    always #(CLK_NS / 2.0) clk = ~clk;

    sema_bank #(
        .NUM_SEM (N),
        .ADDR_W  (ADDR_W),
        .DATA_W  (DATA_W),
        .SET_VAL (32'd1)
    ) dut_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .req_i   (req_i),
        .wr_i    (wr_i),
        .addr_i  (addr_i),
        .wdata_i (wdata_i),
        .ready_o (ready_o),
        .rdata_o (rdata_o)
    );

    int unsigned model [N];
    bit          exp_rdy = 1'b0;
    logic [31:0] exp_data = '0;
    string       exp_tag = "R2";
    int          checks = 0;
    int          errors = 0;
    bit          done = 1'b0;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp, input string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // One bus cycle: compare the previous access's response, then present the next access
    task automatic cyc(input bit rq, input bit w, input int a, input logic [31:0] wd, input string tag);
        @(negedge clk);
        check(exp_tag, 32'(ready_o), 32'(exp_rdy), "ready");
        check(exp_tag, rdata_o, exp_data, "rdata");
        req_i   = rq;
        wr_i    = w;
        addr_i  = ADDR_W'(a);
        wdata_i = wd;
        exp_rdy  = rq;
        exp_data = '0;
        exp_tag  = tag;
        if (rq) begin
            if (w) begin
                if (a < 2 * N) model[a % N] = wd;
            end else if (a < N) begin
                exp_data = model[a];
                model[a] = 1;
            end else if (a < 2 * N) begin
                exp_data = model[a - N];
            end
        end
    endtask

    task automatic peek_all(input string tag);
        for (int i = 0; i < N; i++) cyc(1, 0, N + i, '0, tag);
    endtask

    initial begin
        for (int i = 0; i < N; i++) model[i] = 0;
        repeat (3) @(negedge clk);
        // R1: outputs idle during reset
        check("R1", 32'(ready_o), 32'd0, "ready in reset");
        check("R1", rdata_o, 32'd0, "rdata in reset");
        rst_n = 1'b1;
        cyc(0, 0, 0, '0, "R2");
        // R1: all locks free after reset
        peek_all("R1");
        // R3 / R4: claim lock 3, then observe it through the test window
        cyc(1, 0, 3, '0, "R3");
        cyc(1, 0, N + 3, '0, "R4");
        cyc(0, 0, 0, '0, "R2");
        // R8: consecutive claims of lock 5
        cyc(1, 0, 5, '0, "R8");
        cyc(1, 0, 5, '0, "R8");
        // R6: release lock 3, then reclaim it
        cyc(1, 1, 3, 32'd0, "R9");
        cyc(1, 0, 3, '0, "R6");
        // R6 / R5: store through the test window, poll twice, then claim
        cyc(1, 1, N + 5, 32'hDEAD_BEEF, "R9");
        cyc(1, 0, N + 5, '0, "R6");
        cyc(1, 0, N + 5, '0, "R5");
        cyc(1, 0, 5, '0, "R3");
        cyc(1, 0, N + 5, '0, "R4");
        // R7: unmapped offsets
        cyc(1, 1, 2 * N, 32'h55, "R9");
        cyc(1, 0, 2 * N, '0, "R7");
        cyc(1, 1, 63, 32'h77, "R9");
        cyc(1, 0, 63, '0, "R7");
        peek_all("R7");
        // R2: gaps between accesses
        cyc(0, 0, 1, '0, "R2");
        cyc(1, 0, N + 1, '0, "R5");
        cyc(0, 1, 1, 32'h9, "R2");
        cyc(0, 0, 1, '0, "R2");
        peek_all("R5");
        // Mixed traffic
        for (int k = 0; k < 400; k++) begin
            int  a;
            bit  rq, w;
            string t;
            rq = ($urandom % 4) != 0;
            w  = ($urandom % 3) == 0;
            a  = ($urandom % 5 == 0) ? (2 * N + $urandom % (64 - 2 * N)) : ($urandom % (2 * N));
            if (!rq) t = "R2";
            else if (w) t = "R6";
            else if (a < N) t = "R3";
            else if (a < 2 * N) t = "R5";
            else t = "R7";
            cyc(rq, w, a, $urandom % 3, t);
        end
        peek_all("R6");
        cyc(0, 0, 0, '0, "R2");
        cyc(0, 0, 0, '0, "R2");
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(CLK_NS * 200000.0);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule